// File: doc/BRIEF.md
# Clock-Tile Reconfiguration Sequencer

This block reprograms a clock-synthesis tile through the tile's dynamic reconfiguration port (DRP). A start pulse begins a run. The sequencer first captures eleven 16-bit setting words from a parallel input bus and asserts the tile's reset. It then writes each word to its fixed register address, one access at a time. Each access is a single-cycle enable plus write-enable strobe, followed by a wait for the port's ready.

After the last write completes, the sequencer releases the tile reset and waits a lock-settle interval. That interval is a parameter, derived from the clock frequency and a time in microseconds. It then samples the tile's locked flag and finishes with done. The error flag is also raised if lock is missing, or if any access waits longer than a parameterised ready timeout.

The block runs on the DRP clock. Software or a boot controller only needs to drive start and read the result flags.

Top module: `clk_tile_reprog`

## Requirements
- R1: After the synchronous active-high reset, tile_rst_o, drp_en_o, drp_we_o, busy_o, done_o and err_o are all low.
- R2: After a start pulse taken while idle, busy_o and tile_rst_o are high on the next clock, before any strobe. tile_rst_o stays high across every strobe and falls only after the ready of the last write.
- R3: Slot k (bits k*16 +: 16 of cfg_words_i) is written to the k-th address of this fixed order: 0x08, 0x09, 0x14, 0x15, 0x16, 0x18, 0x19, 0x1A, 0x28, 0x4E, 0x4F.
- R4: Each access raises drp_en_o and drp_we_o together for exactly one clock cycle. No further strobe appears until drp_rdy_i has been seen high for the current access.
- R5: done_o rises exactly SETTLE_CYC+1 clock cycles after tile_rst_o falls at the end of a complete write list. SETTLE_CYC equals (CLK_HZ/1e6) * SETTLE_US.
- R6: At the end of the settle interval, err_o equals the inverse of tile_locked_i. done_o and err_o then hold until the next accepted start.
- R7: If drp_rdy_i does not arrive within TIMEOUT_CYC cycles after a strobe, the sequencer does three things. It releases tile_rst_o, sets done_o and err_o, and issues no further strobe.
- R8: A start pulse during a run is ignored. The words written are those present on cfg_words_i in the cycle start was taken, even if the bus changes later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRP clock, also the sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a reconfiguration run (taken only while idle) |
| cfg_words_i | input | 176 | Eleven 16-bit setting words, slot k at bits k*16 +: 16 |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | Last run has finished; holds until next start |
| err_o | output | 1 | Last run failed (no lock or ready timeout) |
| tile_rst_o | output | 1 | Reset to the clock tile |
| drp_en_o | output | 1 | DRP enable strobe |
| drp_we_o | output | 1 | DRP write-enable strobe |
| drp_addr_o | output | 7 | DRP register address |
| drp_di_o | output | 16 | DRP write data |
| drp_rdy_i | input | 1 | DRP access complete |
| tile_locked_i | input | 1 | Tile locked flag |

## Verification
Two functions can meet in the same cycle. One is a new start request arriving while an access is still waiting for ready. The other is that access's own ready and strobe handling. The bench provokes this by pulsing start in the middle of a run while also changing the setting bus. It judges the outcome from the DRP access log, which must still hold exactly eleven writes carrying the originally captured words.

The ready input and the timeout expiry can also coincide. In that case ready wins. Random ready latencies cover this, together with stalls held on the first and last slots, where the log must stop at the stalled access and err_o must be set.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

  localparam int NUM_WORDS   = 11;
  localparam int SLOT_ADDR_W = 7;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_ISSUE,
    SEQ_WAIT,
    SEQ_SETTLE
  } seq_state_e;

  // Register address of write slot k; the order is the programming order.
  function automatic logic [SLOT_ADDR_W-1:0] slot_addr(input int unsigned k);
    case (k)
      0:       slot_addr = 7'h08;
      1:       slot_addr = 7'h09;
      2:       slot_addr = 7'h14;
      3:       slot_addr = 7'h15;
      4:       slot_addr = 7'h16;
      5:       slot_addr = 7'h18;
      6:       slot_addr = 7'h19;
      7:       slot_addr = 7'h1A;
      8:       slot_addr = 7'h28;
      9:       slot_addr = 7'h4E;
      default: slot_addr = 7'h4F;
    endcase
  endfunction

endpackage

// File: rtl/ctr_drp_write.sv
module ctr_drp_write #(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 7,
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              en_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  input  logic              rdy_i,
  output logic              ok_o,
  output logic              tmo_o
);

  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  logic          busy_q;
  logic [TW-1:0] wait_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      wait_q <= '0;
      en_o   <= 1'b0;
      we_o   <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
      ok_o   <= 1'b0;
      tmo_o  <= 1'b0;
    end else begin
      ok_o  <= 1'b0;
      tmo_o <= 1'b0;
      if (!busy_q) begin
        if (go_i) begin
          en_o   <= 1'b1;
          we_o   <= 1'b1;
          addr_o <= addr_i;
          data_o <= data_i;
          wait_q <= '0;
          busy_q <= 1'b1;
        end
      end else begin
        en_o <= 1'b0;
        we_o <= 1'b0;
        if (rdy_i) begin
          ok_o   <= 1'b1;
          busy_q <= 1'b0;
        end else if (wait_q == TW'(TIMEOUT_CYC - 1)) begin
          tmo_o  <= 1'b1;
          busy_q <= 1'b0;
        end else begin
          wait_q <= wait_q + 1'b1;
        end
      end
    end
  end

  // R4
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    en_o |=> !en_o);

  // R7
  wait_bound_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (wait_q < TW'(TIMEOUT_CYC)));

  // R4
  we_with_en_chk: assert property (@(posedge clk) disable iff (rst)
    we_o |-> en_o);

endmodule

// File: rtl/ctr_settle_wait.sv
module ctr_settle_wait #(
  parameter int CYCLES = 10000
) (
  input  logic clk,
  input  logic rst,
  input  logic go_i,
  output logic exp_o
);

  localparam int CW = $clog2(CYCLES + 1);

  logic          run_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      exp_o <= 1'b0;
    end else begin
      exp_o <= 1'b0;
      if (go_i) begin
        run_q <= 1'b1;
        cnt_q <= '0;
      end else if (run_q) begin
        if (cnt_q == CW'(CYCLES - 1)) begin
          exp_o <= 1'b1;
          run_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R5
  settle_single_chk: assert property (@(posedge clk) disable iff (rst)
    exp_o |=> !exp_o);

endmodule

// File: rtl/clk_tile_reprog.sv
module clk_tile_reprog
  import ctr_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 7,
  parameter int CLK_HZ      = 100_000_000,
  parameter int SETTLE_US   = 100,
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start_i,
  input  logic [NUM_WORDS*DATA_W-1:0]   cfg_words_i,
  output logic                          busy_o,
  output logic                          done_o,
  output logic                          err_o,
  output logic                          tile_rst_o,
  output logic                          drp_en_o,
  output logic                          drp_we_o,
  output logic [ADDR_W-1:0]             drp_addr_o,
  output logic [DATA_W-1:0]             drp_di_o,
  input  logic                          drp_rdy_i,
  input  logic                          tile_locked_i
);

  localparam int SETTLE_CYC = (CLK_HZ / 1_000_000) * SETTLE_US;
  localparam int IDX_W      = $clog2(NUM_WORDS);

  seq_state_e        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] words_q [NUM_WORDS];

  logic              acc_go;
  logic              acc_ok;
  logic              acc_tmo;
  logic              settle_go;
  logic              settle_exp;
  logic              last_slot;
  logic [ADDR_W-1:0] cur_addr;

  assign last_slot = (idx_q == IDX_W'(NUM_WORDS - 1));
  assign acc_go    = (state_q == SEQ_ISSUE);
  assign settle_go = (state_q == SEQ_WAIT) && acc_ok && !acc_tmo && last_slot;
  assign cur_addr  = ADDR_W'(slot_addr(32'(idx_q)));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= SEQ_IDLE;
      idx_q      <= '0;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      tile_rst_o <= 1'b0;
      for (int k = 0; k < NUM_WORDS; k++) words_q[k] <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (start_i) begin
            for (int k = 0; k < NUM_WORDS; k++)
              words_q[k] <= cfg_words_i[k*DATA_W +: DATA_W];
            idx_q      <= '0;
            busy_o     <= 1'b1;
            done_o     <= 1'b0;
            err_o      <= 1'b0;
            tile_rst_o <= 1'b1;
            state_q    <= SEQ_ISSUE;
          end
        end
        SEQ_ISSUE: state_q <= SEQ_WAIT;
        SEQ_WAIT: begin
          if (acc_tmo) begin
            tile_rst_o <= 1'b0;
            err_o      <= 1'b1;
            done_o     <= 1'b1;
            busy_o     <= 1'b0;
            state_q    <= SEQ_IDLE;
          end else if (acc_ok) begin
            if (last_slot) begin
              tile_rst_o <= 1'b0;
              state_q    <= SEQ_SETTLE;
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= SEQ_ISSUE;
            end
          end
        end
        SEQ_SETTLE: begin
          if (settle_exp) begin
            done_o  <= 1'b1;
            err_o   <= !tile_locked_i;
            busy_o  <= 1'b0;
            state_q <= SEQ_IDLE;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  ctr_drp_write #(
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_access (
    .clk    (clk),
    .rst    (rst),
    .go_i   (acc_go),
    .addr_i (cur_addr),
    .data_i (words_q[idx_q]),
    .en_o   (drp_en_o),
    .we_o   (drp_we_o),
    .addr_o (drp_addr_o),
    .data_o (drp_di_o),
    .rdy_i  (drp_rdy_i),
    .ok_o   (acc_ok),
    .tmo_o  (acc_tmo)
  );

  ctr_settle_wait #(
    .CYCLES (SETTLE_CYC)
  ) u_settle (
    .clk   (clk),
    .rst   (rst),
    .go_i  (settle_go),
    .exp_o (settle_exp)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!tile_rst_o && !drp_en_o && !busy_o && !done_o));

  // R2
  strobe_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
    drp_en_o |-> tile_rst_o);

  // R2
  settle_released_chk: assert property (@(posedge clk) disable iff (rst)
    settle_exp |-> !tile_rst_o);

  // R8
  strobe_busy_chk: assert property (@(posedge clk) disable iff (rst)
    drp_en_o |-> busy_o);

endmodule

// File: tb/test_clk_tile_reprog.sv
`timescale 1ns/1ps
module test_clk_tile_reprog;

  localparam int NW     = 11;
  localparam int DW     = 16;
  localparam int SETTLE = 20;
  localparam int TMO    = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [NW*DW-1:0] cfg = '0;
  logic             rdy = 1'b0;
  logic             locked = 1'b0;
  logic             busy_o, done_o, err_o, tile_rst_o, drp_en_o, drp_we_o;
  logic [6:0]       drp_addr_o;
  logic [DW-1:0]    drp_di_o;

  int n_chk = 0;
  int n_fail = 0;
  int log_n = 0;
  int stall_at = -1;
  int dly_max = 4;
  int cyc = 0;
  int fall_cyc = -1;
  int done_cyc = -1;
  logic [6:0]    log_a [32];
  logic [DW-1:0] log_d [32];

  always #5 clk = ~clk;

  clk_tile_reprog #(
    .DATA_W(DW), .ADDR_W(7), .CLK_HZ(1_000_000), .SETTLE_US(SETTLE), .TIMEOUT_CYC(TMO)
  ) i_clk_tile_reprog (
    .clk(clk), .rst(rst), .start_i(start), .cfg_words_i(cfg),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .tile_rst_o(tile_rst_o),
    .drp_en_o(drp_en_o), .drp_we_o(drp_we_o), .drp_addr_o(drp_addr_o),
    .drp_di_o(drp_di_o), .drp_rdy_i(rdy), .tile_locked_i(locked)
  );

  function automatic logic [6:0] exp_addr(input int k);
    logic [6:0] t [NW] = '{7'h08, 7'h09, 7'h14, 7'h15, 7'h16, 7'h18,
                           7'h19, 7'h1A, 7'h28, 7'h4E, 7'h4F};
    return t[k];
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // DRP responder and timing monitor, all activity at the falling edge
  initial begin
    int   cnt;
    logic prev_en, prev_trst, prev_done;
    cnt = 0; prev_en = 0; prev_trst = 0; prev_done = 0;
    forever begin
      @(negedge clk);
      cyc++;
      rdy = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) rdy = 1'b1;
      end
      if (drp_en_o) begin
        chk(drp_we_o == 1'b1, "R4 we with en", drp_we_o, 1);
        chk(!prev_en, "R4 one-cycle strobe", prev_en, 0);
        chk(cnt == 0 && !rdy, "R4 strobe before ready", cnt, 0);
        chk(tile_rst_o == 1'b1, "R2 reset during write", tile_rst_o, 1);
        if (log_n < 32) begin
          log_a[log_n] = drp_addr_o;
          log_d[log_n] = drp_di_o;
        end
        if (log_n != stall_at) cnt = int'($urandom_range(0, dly_max)) + 1;
        log_n++;
      end
      if (prev_trst && !tile_rst_o) fall_cyc = cyc;
      if (!prev_done && done_o) done_cyc = cyc;
      prev_en = drp_en_o; prev_trst = tile_rst_o; prev_done = done_o;
    end
  end

  task automatic run(input logic [NW*DW-1:0] w, input bit lk, input int stall, input bit poke);
    int  k;
    bit  hold_err;
    int  hold_n;
    cfg = w; locked = lk; stall_at = stall; log_n = 0; fall_cyc = -1; done_cyc = -1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy_o && tile_rst_o && !drp_en_o, "R2 reset before first strobe",
        {busy_o, tile_rst_o, drp_en_o}, 3'b110);
    cfg = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    k = 0;
    while (!done_o && k < 5000) begin
      @(negedge clk);
      k++;
      start = (poke && (k == 20 || k == 21));
      if (poke && k == 20) cfg = ~w;
    end
    start = 1'b0;
    if (stall < 0) begin
      chk(log_n == NW, "R8 access count", log_n, NW);
      for (int i = 0; i < NW && i < log_n; i++) begin
        chk(log_a[i] == exp_addr(i), "R3 address order", log_a[i], exp_addr(i));
        chk(log_d[i] == w[i*DW +: DW], "R3 slot data", log_d[i], w[i*DW +: DW]);
      end
      chk(done_cyc - fall_cyc == SETTLE + 1, "R5 settle delay", done_cyc - fall_cyc, SETTLE + 1);
      chk(err_o == !lk, "R6 lock result", err_o, !lk);
    end else begin
      chk(log_n == stall + 1, "R7 strobes stop", log_n, stall + 1);
      chk(err_o == 1'b1, "R7 timeout error", err_o, 1);
    end
    chk(!tile_rst_o && !busy_o, "R2 reset released at end", {tile_rst_o, busy_o}, 0);
    hold_err = err_o; hold_n = log_n;
    locked = ~locked;
    repeat (6) @(negedge clk);
    chk(done_o && err_o == hold_err, "R6 result held", {done_o, err_o}, {1'b1, hold_err});
    chk(log_n == hold_n, "R7 no strobe after finish", log_n, hold_n);
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk({tile_rst_o, drp_en_o, drp_we_o, busy_o, done_o, err_o} == 6'b0, "R1 reset state",
        {tile_rst_o, drp_en_o, drp_we_o, busy_o, done_o, err_o}, 0);
    dly_max = 0;
    run('0, 1'b1, -1, 1'b0);
    run('1, 1'b0, -1, 1'b0);
    dly_max = 4;
    run({$urandom, $urandom, $urandom, $urandom, $urandom, $urandom}, 1'b1, -1, 1'b1); // R8
    run({$urandom, $urandom, $urandom, $urandom, $urandom, $urandom}, 1'b1, 0, 1'b0);  // R7
    run({$urandom, $urandom, $urandom, $urandom, $urandom, $urandom}, 1'b1, NW - 1, 1'b0);
    dly_max = TMO - 2;
    for (int r = 0; r < 6; r++)
      run({$urandom, $urandom, $urandom, $urandom, $urandom, $urandom},
          1'($urandom_range(0, 1)), -1, 1'(r % 2));
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule